// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt lines (32 by default) that are not related to its clock. Each line passes through a two-flop synchroniser. The block then checks the line against a sense mode chosen for it alone: active-low level, active-high level, falling edge, rising edge, or either edge. When the condition is met, the block records it in a sticky detect bit for that line. Each line has its own interrupt output, which is high while the line's detect bit and enable bit are both set.

Software reaches the block over a plain 32-bit register bus: an address, a write strobe, write data and read data. Reads are combinational and writes take effect on the next clock edge. Bit n of every mask register belongs to line n.

The registers are:

| Offset | Read | Write |
|---|---|---|
| 0x000 | masked request | ignored |
| 0x004 | enable mask | a one disables the line |
| 0x008 | enable mask | a one enables the line |
| 0x100 | pending detections | a one clears the detect bit |
| 0x180 + 4·n | sense field of line n | sense field of line n |

Top module: `extint_sense_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable bit, every detect bit and every sense field is zero, and every interrupt output is low.
- R2: Each input goes through two synchronising flops before it is evaluated. Take an input that changes just after a clock edge, on a line in high-level mode. Its detect bit, and its interrupt output if the line is enabled, rise at the third rising clock edge after the change.
- R3: The sense field is bits [5:0] of the line's configuration register. Code 0x01 selects low level and code 0x02 selects high level. In a level mode the detect bit is set on every cycle the synchronised level is active, so clearing it while the level persists has no lasting effect.
- R4: Code 0x08 selects rising edge, code 0x04 falling edge and code 0x0C both edges. An edge is found by comparing the synchronised input with its sample from the previous cycle. A steady input after the edge does not set the bit again.
- R5: Reading offset 0x100 returns the detect bits. Writing it clears each detect bit whose write-data bit is one. Zero bits leave their detect bits unchanged.
- R6: If a clear write and a new detection hit the same line in the same cycle, the detect bit ends up set.
- R7: A one written at offset 0x008 sets that line's enable bit, and a one written at offset 0x004 clears it. Zero bits in either write have no effect. Reading either offset returns the enable mask.
- R8: Interrupt output n equals detect bit n AND enable bit n. Reading offset 0x000 returns the same vector, and writes to offset 0x000 change nothing.
- R9: The configuration register of line n sits at offset 0x180 + 4·n. Bits above bit 5 read back as zero. A sense field holding any code other than the five listed, including zero, detects nothing.
- R10: Reads from offsets with no register return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | NUM_LINES | Asynchronous external interrupt inputs |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| line_irq | output | NUM_LINES | Per-line interrupt, detect AND enable |

## Verification
The bench lines up a clear write with the exact edge on which a fresh rising-edge detection lands. A design that lets the clear win would drop that interrupt and leave detect bit 3 at zero. It also clears a level-mode line while its level is still present, where a design that treats level like edge would read back zero. In addition it checks that a steady input after an edge does not set the bit again, that falling mode ignores rises, and that unsupported or zero codes detect nothing. The interrupt output is timed to the third edge after an input change, so a synchroniser that is one stage short or one stage long shows up as an early or late output. Writes with zero bits, writes to the read-only and unmapped offsets, and config writes with junk in the upper bits are each read back to show they changed nothing they should not.

// File: rtl/extint_pkg.sv
// Shared constants and the sense decode for the external interrupt sense controller.
// Assumes byte offsets on a 32-bit register bus.
package extint_pkg;

    localparam int unsigned OFS_REQ   = 32'h000;
    localparam int unsigned OFS_ENCLR = 32'h004;
    localparam int unsigned OFS_ENSET = 32'h008;
    localparam int unsigned OFS_DET   = 32'h100;
    localparam int unsigned OFS_CFG   = 32'h180;

    localparam int SENSE_W = 6;
    typedef logic [SENSE_W-1:0] sense_t;

    localparam sense_t SENSE_LOW  = 6'h01;
    localparam sense_t SENSE_HIGH = 6'h02;
    localparam sense_t SENSE_FALL = 6'h04;
    localparam sense_t SENSE_RISE = 6'h08;
    localparam sense_t SENSE_BOTH = 6'h0C;

    // Returns one when the synchronised sample meets the selected sense condition.
    function automatic logic sense_hit(sense_t mode, logic cur, logic prev);
        case (mode)
            SENSE_LOW:  return ~cur;
            SENSE_HIGH: return cur;
            SENSE_FALL: return prev & ~cur;
            SENSE_RISE: return cur & ~prev;
            SENSE_BOTH: return cur ^ prev;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
// Multi-stage flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no cross-bit coherence is promised.
module extint_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the raw inputs through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/extint_line.sv
// Detector for one interrupt line: keeps the previous synchronised sample and a
// sticky detect bit. Assumes cur is already synchronised to clk.
module extint_line
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cur,
    input  sense_t mode,
    input  logic   clr,
    output logic   det
);

    logic prev_q;
    logic hit;

    assign hit = sense_hit(mode, cur, prev_q);

    // Remember the last synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Sticky detect bit: a new hit outranks a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) det <= 1'b0;
        else        det <= hit | (det & ~clr);
    end

endmodule

// File: rtl/extint_regs.sv
// Register file: enable mask with set/clear offsets, per-line sense fields,
// detect clear strobes and combinational readback. Assumes NUM_LINES <= 32.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    input  logic [NUM_LINES-1:0]  det,
    output logic [31:0]           bus_rdata,
    output logic [NUM_LINES-1:0]  en,
    output logic [NUM_LINES-1:0]  det_clr,
    output sense_t [NUM_LINES-1:0] line_mode
);

    logic hit_req, hit_enclr, hit_enset, hit_det;
    logic [NUM_LINES-1:0] cfg_hit;
    logic [NUM_LINES-1:0] wmask;
    sense_t cfg_q [NUM_LINES];

    assign hit_req   = (bus_addr == ADDR_W'(OFS_REQ));
    assign hit_enclr = (bus_addr == ADDR_W'(OFS_ENCLR));
    assign hit_enset = (bus_addr == ADDR_W'(OFS_ENSET));
    assign hit_det   = (bus_addr == ADDR_W'(OFS_DET));
    assign wmask     = bus_wdata[NUM_LINES-1:0];

    assign det_clr = (bus_we && hit_det) ? wmask : '0;

    // Enable mask: ones in a set write enable, ones in a clear write disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en <= '0;
        else if (bus_we && hit_enset) en <= en | wmask;
        else if (bus_we && hit_enclr) en <= en & ~wmask;
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_cfg
        assign cfg_hit[n] = (bus_addr == ADDR_W'(OFS_CFG + 4 * n));

        // Per-line sense field, written only at its own offset.
        always_ff @(posedge clk) begin
            if (!rst_n)                   cfg_q[n] <= '0;
            else if (bus_we && cfg_hit[n]) cfg_q[n] <= bus_wdata[SENSE_W-1:0];
        end

        assign line_mode[n] = cfg_q[n];
    end

    // Combinational readback; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_req)                  bus_rdata[NUM_LINES-1:0] = det & en;
        else if (hit_enclr || hit_enset) bus_rdata[NUM_LINES-1:0] = en;
        else if (hit_det)             bus_rdata[NUM_LINES-1:0] = det;
        else begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (cfg_hit[n]) bus_rdata[SENSE_W-1:0] = cfg_q[n];
            end
        end
    end

endmodule

// File: rtl/extint_sense_ctrl.sv
// Top of the external interrupt sense controller: synchroniser, one detector per
// line and the register file. Assumes line_in is asynchronous to clk.
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] line_irq
);

    logic [NUM_LINES-1:0] sync_v;
    logic [NUM_LINES-1:0] det_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] clr_v;
    sense_t [NUM_LINES-1:0] mode_v;

    extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (sync_v)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        extint_line u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .cur  (sync_v[n]),
            .mode (mode_v[n]),
            .clr  (clr_v[n]),
            .det  (det_q[n])
        );
    end

    extint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .det      (det_q),
        .bus_rdata(bus_rdata),
        .en       (en_q),
        .det_clr  (clr_v),
        .line_mode(mode_v)
    );

    assign line_irq = det_q & en_q;

endmodule

// File: rtl/extint_sense_chk.sv
// Assertion checker for extint_sense_ctrl, attached by bind below.
// Assumes the bus is observed on the same clock as the block.
module extint_sense_chk
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] line_irq,
    input logic [NUM_LINES-1:0] det_q,
    input logic [NUM_LINES-1:0] en_q
);

    logic [NUM_LINES-1:0] clr_mask;
    logic in_cfg, mapped;
    int unsigned a;

    assign a        = int'(bus_addr);
    assign clr_mask = (bus_we && a == OFS_DET) ? bus_wdata[NUM_LINES-1:0] : '0;
    assign in_cfg   = (a >= OFS_CFG) && (a < OFS_CFG + 4 * NUM_LINES) && (bus_addr[1:0] == 2'b00);
    assign mapped   = in_cfg || a == OFS_REQ || a == OFS_ENCLR || a == OFS_ENSET || a == OFS_DET;

    // R8
    req_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a == OFS_REQ) |-> (bus_rdata[NUM_LINES-1:0] == line_irq));

    // R7
    enset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a == OFS_ENSET) |=> ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    // R7
    enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a == OFS_ENCLR) |=> ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R5
    det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(det_q) & ~det_q & ~$past(clr_mask)) == '0);

    // R9
    cfg_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_cfg |-> (bus_rdata[31:SENSE_W] == '0));

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 32'h0));

endmodule

bind extint_sense_ctrl extint_sense_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .line_irq (line_irq),
    .det_q    (det_q),
    .en_q     (en_q)
);

// File: tb/sim_extint_sense_ctrl.sv
`timescale 1ns/1ps
module sim_extint_sense_ctrl;

    localparam int N  = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  tin = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wd = '0;
    logic [31:0]   rd;
    logic [N-1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    extint_sense_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(tin), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wd), .bus_rdata(rd), .line_irq(irq)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] hist[$];
    logic [N-1:0] m_en, m_det, nd, c_s, p_s;
    logic [5:0]   m_cfg [N];
    bit           clr_b;

    function automatic bit m_hit(logic [5:0] md, bit c, bit p);
        if (md == 6'h01) return !c;
        if (md == 6'h02) return c;
        if (md == 6'h04) return p && !c;
        if (md == 6'h08) return c && !p;
        if (md == 6'h0C) return c != p;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            repeat (3) hist.push_back('0);
            m_en  = '0;
            m_det = '0;
            for (int i = 0; i < N; i++) m_cfg[i] = '0;
        end else begin
            c_s = hist[1];
            p_s = hist[2];
            for (int i = 0; i < N; i++) begin
                clr_b = we && (addr == 12'h100) && wd[i];
                nd[i] = m_hit(m_cfg[i], c_s[i], p_s[i]) || (m_det[i] && !clr_b);
            end
            if (we && addr == 12'h008) m_en = m_en | wd;
            if (we && addr == 12'h004) m_en = m_en & ~wd;
            for (int i = 0; i < N; i++)
                if (we && addr == AW'(12'h180 + 4 * i)) m_cfg[i] = wd[5:0];
            m_det = nd;
            hist.push_front(tin);
            void'(hist.pop_back());
        end
    end

    // R8: interrupt outputs compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_det & m_en)) begin
                fails++;
                $display("FAIL R8 per-cycle line_irq act=%h exp=%h", irq, m_det & m_en);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wd = '0; addr = '0;
    endtask

    task automatic rdv(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rd;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdv(12'h000, v); chk("R1 request after reset", v, 32'h0);
        rdv(12'h004, v); chk("R1 enable after reset", v, 32'h0);
        rdv(12'h100, v); chk("R1 detect after reset", v, 32'h0);
        rdv(12'h180, v); chk("R1 cfg0 after reset", v, 32'h0);
        chk("R1 line_irq after reset", irq, 32'h0);

        // configure the lines
        wr(12'h180, 32'h01);            // line0 low level
        wr(12'h184, 32'h02);            // line1 high level
        wr(12'h188, 32'h04);            // line2 falling
        wr(12'h18C, 32'h08);            // line3 rising
        wr(12'h190, 32'h0C);            // line4 both
        wr(12'h194, 32'h03);            // line5 unsupported
        wr(12'h198, 32'hFFFF_FFFF);     // line6 -> 0x3F unsupported
        wr(12'h1FC, 32'hFFFF_FFC2);     // line31 high level, junk above
        rdv(12'h1FC, v); chk("R9 cfg31 upper bits zero", v, 32'h02);
        rdv(12'h198, v); chk("R9 cfg6 readback", v, 32'h3F);
        rdv(12'h190, v); chk("R9 cfg4 readback", v, 32'h0C);

        // R7 enables
        wr(12'h008, 32'h8000_00FF);
        rdv(12'h004, v); chk("R7 enable via 0x04", v, 32'h8000_00FF);
        rdv(12'h008, v); chk("R7 enable via 0x08", v, 32'h8000_00FF);

        // R2 latency on line31
        tin[31] = 1'b1;
        idle(2); chk("R2 not yet after two edges", 32'(irq[31]), 32'h0);
        idle(1); chk("R2 set at third edge", 32'(irq[31]), 32'h1);

        // R3 low level on line0: clear has no lasting effect
        wr(12'h100, 32'h1);
        rdv(12'h100, v); chk("R3 level persists after clear", 32'(v[0]), 32'h1);
        tin[0] = 1'b1; idle(5);
        wr(12'h100, 32'h1);
        rdv(12'h100, v); chk("R3 cleared once level gone", 32'(v[0]), 32'h0);

        // R4 rising on line3: single one-cycle pulse
        tin[3] = 1'b1; idle(1); tin[3] = 1'b0; idle(4);
        rdv(12'h100, v); chk("R4 rising pulse detected", 32'(v[3]), 32'h1);
        wr(12'h100, 32'h8);
        idle(4);
        rdv(12'h100, v); chk("R4 rising not on low", 32'(v[3]), 32'h0);

        // R4 both edges on line4
        tin[4] = 1'b1; idle(5);
        rdv(12'h100, v); chk("R4 both: rise", 32'(v[4]), 32'h1);
        wr(12'h100, 32'h10); idle(3);
        rdv(12'h100, v); chk("R4 both: steady high no redetect", 32'(v[4]), 32'h0);
        tin[4] = 1'b0; idle(5);
        rdv(12'h100, v); chk("R4 both: fall", 32'(v[4]), 32'h1);

        // R4 falling on line2
        tin[2] = 1'b1; idle(5);
        rdv(12'h100, v); chk("R4 falling ignores rise", 32'(v[2]), 32'h0);
        tin[2] = 1'b0; idle(5);
        rdv(12'h100, v); chk("R4 falling detected", 32'(v[2]), 32'h1);

        // R5 zero bits leave detections alone
        wr(12'h100, 32'h0);
        rdv(12'h100, v); chk("R5 zero write keeps line2", 32'(v[2]), 32'h1);
        wr(12'h100, 32'h4);
        rdv(12'h100, v); chk("R5 one write clears line2", 32'(v[2]), 32'h0);

        // R9 unsupported codes and zero code detect nothing
        tin[5] = 1'b1; tin[6] = 1'b1; tin[7] = 1'b1; idle(5);
        tin[5] = 1'b0; tin[6] = 1'b0; tin[7] = 1'b0; idle(5);
        rdv(12'h100, v); chk("R9 lines 5..7 no detect", 32'(v[7:5]), 32'h0);

        // R6 clear coinciding with a fresh rising detection on line3
        idle(2);
        tin[3] = 1'b1;
        idle(1);
        wr(12'h100, 32'h8);
        rdv(12'h100, v); chk("R6 detection beats clear", 32'(v[3]), 32'h1);
        tin[3] = 1'b0;

        // R7 / R8 enable clear masks the output but keeps the detection
        tin[1] = 1'b1; idle(5);
        wr(12'h004, 32'h2);
        rdv(12'h004, v); chk("R7 clear bit1", v, 32'h8000_00FD);
        chk("R8 masked line1 output low", 32'(irq[1]), 32'h0);
        rdv(12'h100, v); chk("R8 line1 detect still set", 32'(v[1]), 32'h1);
        rdv(12'h000, v); chk("R8 request hides line1", 32'(v[1]), 32'h0);
        wr(12'h004, 32'h0);
        wr(12'h008, 32'h0);
        rdv(12'h004, v); chk("R7 zero writes no effect", v, 32'h8000_00FD);
        wr(12'h008, 32'h2);
        idle(1); chk("R8 line1 output after re-enable", 32'(irq[1]), 32'h1);

        // R8 writes to request offset ignored
        wr(12'h000, 32'hFFFF_FFFF);
        rdv(12'h004, v); chk("R8 request write keeps enables", v, 32'h8000_00FF);
        rdv(12'h100, v); chk("R8 request write keeps line1 detect", 32'(v[1]), 32'h1);

        // R10 unmapped offsets
        rdv(12'h00C, v); chk("R10 read 0x00C", v, 32'h0);
        rdv(12'h104, v); chk("R10 read 0x104", v, 32'h0);
        rdv(12'h17C, v); chk("R10 read 0x17C", v, 32'h0);
        rdv(12'h182, v); chk("R10 read 0x182", v, 32'h0);
        wr(12'h00C, 32'h0);
        wr(12'h182, 32'h3F);
        rdv(12'h004, v); chk("R10 unmapped write keeps enables", v, 32'h8000_00FF);
        rdv(12'h180, v); chk("R10 unmapped write keeps cfg0", v, 32'h01);

        idle(3);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule